// File: doc/BRIEF.md
# Register-Window Bus Command Bridge

This block gives a host that can only perform single-word register reads and writes a way to move data on an internal memory bus. The host sees a small set of control registers and two data windows. It loads outgoing words into the write window, programs a word count, and then writes a bus address into one of two start registers. Writing the start register is the command: the bridge immediately begins a sequence of bus accesses at that address, four bytes apart.

On the bus side the bridge is the only master. It raises a request with an address, a direction and, for writes, a data word, and holds them until the slave acknowledges. Read results are stored into the read window in the order they were fetched. The host polls a completion flag and then collects the results through the read window. A capability register reports the longest burst the bridge will run, and longer counts are clamped to it.

The host port is word addressed. Bits 7:6 of the host address pick a region (00 registers, 10 read window, 11 write window). Inside a window the buffer entry is formed as {address bits above 7, address bits 5:0}, so each window page covers 64 entries and further pages are reached through the upper address bits.

Top module: `regwin_bridge`

## Requirements
- R1: After reset the completion flag (status word 0, bit 0) reads 1, the size register (word 2) reads 0 and the bus request is low.
- R2: Word 3 reads MAX_BURST shifted left by 4 with REV in bits 3:0; word 1 and region 01 read 0; words 4 and 8 read back the last start address written; the write window reads 0.
- R3: A write to word 8 starts bus writes of write-window entries 0..N-1 to addresses A, A+4, ... with the written value A as start.
- R4: A write to word 4 starts bus reads from A, A+4, ...; the word of beat i is returned by read-window entry i.
- R5: A size of 0 performs exactly one bus access; a size N in 1..MAX_BURST performs exactly N accesses and no others.
- R6: A size above MAX_BURST performs exactly MAX_BURST accesses.
- R7: The completion flag reads 0 from the cycle after a start write until the final acknowledge of that command, then 1.
- R8: While a command runs, host writes to the size register, the write window and both start registers have no effect: no extra command starts, the size keeps its value and buffered write data is preserved.
- R9: The request stays high with unchanged address, direction and write data until acknowledged; after a non-final acknowledge the next beat's address, four higher, is presented on the next cycle.
- R10: Host read data appears on h_rdata one clock after the cycle in which h_rd is high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host register write strobe |
| h_rd | input | 1 | Host register read strobe |
| h_addr | input | BUF_AW+2 | Host word address |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data, registered |
| b_req | output | 1 | Bus request |
| b_we | output | 1 | Bus direction, 1 = write |
| b_addr | output | ADDR_W | Bus byte address |
| b_wdata | output | DATA_W | Bus write data |
| b_rdata | input | DATA_W | Bus read data, valid with acknowledge |
| b_ack | input | 1 | Bus acknowledge |

## Verification
A corrupted beat index or stale end-of-burst count shows up on the bus within one beat as a wrong address step or an extra or missing access, which the bus-side monitor and the per-command beat count catch before the completion flag returns. A wrong buffer index or a lost read word is only visible after completion, when the host sweeps the read window or the slave memory is compared against the pattern loaded. A busy flag that drops early or never rises shows in the very next status read after the start write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    // Host address region, taken from host address bits 7:6
    localparam logic [1:0] REGION_REGS = 2'b00;
    localparam logic [1:0] REGION_RBUF = 2'b10;
    localparam logic [1:0] REGION_WBUF = 2'b11;

    // Register selectors inside the register region (host word offsets)
    localparam logic [5:0] SEL_STATUS = 6'h00;
    localparam logic [5:0] SEL_SIZE   = 6'h02;
    localparam logic [5:0] SEL_CAPS   = 6'h03;
    localparam logic [5:0] SEL_RSTART = 6'h04;
    localparam logic [5:0] SEL_WSTART = 6'h08;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/regwin_wordbuf.sv
module regwin_wordbuf #(
    parameter int AW = 8,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ridx,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];

endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
    import regwin_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BUF_AW    = 8,
    parameter int MAX_BURST = 256,
    localparam int CNT_W    = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_size,
    output logic              busy,
    output logic [BUF_AW-1:0] wbuf_idx,
    input  logic [DATA_W-1:0] wbuf_data,
    output logic              rbuf_we,
    output logic [BUF_AW-1:0] rbuf_idx,
    output logic [DATA_W-1:0] rbuf_data,
    output logic              b_req,
    output logic              b_we,
    output logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_wdata,
    input  logic [DATA_W-1:0] b_rdata,
    input  logic              b_ack
);

    typedef struct packed {
        seq_state_t        state;
        logic              write;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  idx;
        logic [CNT_W-1:0]  last;
    } seq_regs_t;

    seq_regs_t q, d;
    logic [CNT_W-1:0] beats;

    // Clamp the programmed size into 1..MAX_BURST
    always_comb begin
        if (start_size == '0) begin
            beats = CNT_W'(1);
        end else if (start_size > DATA_W'(MAX_BURST)) begin
            beats = CNT_W'(MAX_BURST);
        end else begin
            beats = CNT_W'(start_size);
        end
    end

    always_comb begin
        d = q;
        unique case (q.state)
            SEQ_IDLE: begin
                if (start) begin
                    d.state = SEQ_RUN;
                    d.write = start_write;
                    d.base  = start_addr;
                    d.idx   = '0;
                    d.last  = beats - CNT_W'(1);
                end
            end
            SEQ_RUN: begin
                if (b_ack) begin
                    if (q.idx == q.last) begin
                        d.state = SEQ_IDLE;
                    end else begin
                        d.idx = q.idx + CNT_W'(1);
                    end
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: SEQ_IDLE, write: 1'b0, base: '0, idx: '0, last: '0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.state == SEQ_RUN);
    assign b_req     = busy;
    assign b_we      = busy && q.write;
    assign b_addr    = q.base + (ADDR_W'(q.idx) << 2);
    assign wbuf_idx  = BUF_AW'(q.idx);
    assign b_wdata   = wbuf_data;
    assign rbuf_we   = busy && b_ack && !q.write;
    assign rbuf_idx  = BUF_AW'(q.idx);
    assign rbuf_data = b_rdata;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        b_req && !b_ack |=> b_req && $stable(b_addr) && $stable(b_we) && $stable(b_wdata)); // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        b_req && b_ack |=> !b_req || (b_addr == $past(b_addr) + ADDR_W'(4))); // R9
    AST_BURST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.last < CNT_W'(MAX_BURST)) && (q.idx <= q.last)); // R6

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int BUF_AW    = 8,
    parameter int MAX_BURST = 256,
    parameter int REV       = 1,
    localparam int HOST_AW  = BUF_AW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_wr,
    input  logic               h_rd,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic [DATA_W-1:0]  h_rdata,
    output logic               b_req,
    output logic               b_we,
    output logic [ADDR_W-1:0]  b_addr,
    output logic [DATA_W-1:0]  b_wdata,
    input  logic [DATA_W-1:0]  b_rdata,
    input  logic               b_ack
);

    localparam logic [DATA_W-1:0] CAPS_WORD =
        (DATA_W'(MAX_BURST) << 4) | DATA_W'(REV & 15);

    typedef struct packed {
        logic [DATA_W-1:0] size;
        logic [ADDR_W-1:0] base;
        logic [DATA_W-1:0] rdata;
    } top_regs_t;

    top_regs_t q, d;

    // Host address decode
    logic [1:0]        region;
    logic [BUF_AW-7:0] page;
    logic [5:0]        sel;
    logic [BUF_AW-1:0] win_idx;
    logic              in_regs;
    logic              busy;
    logic              wr_ok;
    logic              launch;
    logic              launch_write;
    logic              wbuf_we;

    assign region  = h_addr[7:6];
    assign page    = h_addr[HOST_AW-1:8];
    assign sel     = h_addr[5:0];
    assign win_idx = {page, sel};
    assign in_regs = (region == REGION_REGS) && (page == '0);

    assign wr_ok        = h_wr && !busy;
    assign launch       = wr_ok && in_regs && (sel == SEL_RSTART || sel == SEL_WSTART);
    assign launch_write = (sel == SEL_WSTART);
    assign wbuf_we      = wr_ok && (region == REGION_WBUF);

    // Buffers
    logic [BUF_AW-1:0] seq_widx;
    logic [DATA_W-1:0] seq_wdata;
    logic              rbuf_we;
    logic [BUF_AW-1:0] rbuf_widx;
    logic [DATA_W-1:0] rbuf_wdata;
    logic [DATA_W-1:0] rbuf_rdata;

    regwin_wordbuf #(.AW(BUF_AW), .DW(DATA_W)) i_wbuf (
        .clk   (clk),
        .we    (wbuf_we),
        .widx  (win_idx),
        .wdata (h_wdata),
        .ridx  (seq_widx),
        .rdata (seq_wdata)
    );

    regwin_wordbuf #(.AW(BUF_AW), .DW(DATA_W)) i_rbuf (
        .clk   (clk),
        .we    (rbuf_we),
        .widx  (rbuf_widx),
        .wdata (rbuf_wdata),
        .ridx  (win_idx),
        .rdata (rbuf_rdata)
    );

    regwin_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BUF_AW    (BUF_AW),
        .MAX_BURST (MAX_BURST)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (launch),
        .start_write (launch_write),
        .start_addr  (ADDR_W'(h_wdata)),
        .start_size  (q.size),
        .busy        (busy),
        .wbuf_idx    (seq_widx),
        .wbuf_data   (seq_wdata),
        .rbuf_we     (rbuf_we),
        .rbuf_idx    (rbuf_widx),
        .rbuf_data   (rbuf_wdata),
        .b_req       (b_req),
        .b_we        (b_we),
        .b_addr      (b_addr),
        .b_wdata     (b_wdata),
        .b_rdata     (b_rdata),
        .b_ack       (b_ack)
    );

    // Read multiplexer
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (in_regs) begin
            unique case (sel)
                SEL_STATUS: rd_val[0] = ~busy;
                SEL_SIZE:   rd_val    = q.size;
                SEL_CAPS:   rd_val    = CAPS_WORD;
                SEL_RSTART: rd_val    = DATA_W'(q.base);
                SEL_WSTART: rd_val    = DATA_W'(q.base);
                default:    rd_val    = '0;
            endcase
        end else if (region == REGION_RBUF) begin
            rd_val = rbuf_rdata;
        end
    end

    always_comb begin
        d = q;
        if (wr_ok && in_regs) begin
            if (sel == SEL_SIZE) begin
                d.size = h_wdata;
            end
            if (sel == SEL_RSTART || sel == SEL_WSTART) begin
                d.base = ADDR_W'(h_wdata);
            end
        end
        if (h_rd) begin
            d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{size: '0, base: '0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign h_rdata = q.rdata;

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy); // R7
    AST_WBUF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wbuf_we); // R8
    AST_SIZE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy || $stable(q.size)); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !h_rd |=> $stable(h_rdata)); // R10

endmodule

// File: tb/test_regwin_bridge.sv
module test_regwin_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 32;
    localparam int AW   = 32;
    localparam int BAW  = 8;
    localparam int MAXB = 256;
    localparam int HAW  = BAW + 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           h_wr = 1'b0;
    logic           h_rd = 1'b0;
    logic [HAW-1:0] h_addr = '0;
    logic [DW-1:0]  h_wdata = '0;
    logic [DW-1:0]  h_rdata;
    logic           b_req;
    logic           b_we;
    logic [AW-1:0]  b_addr;
    logic [DW-1:0]  b_wdata;
    logic [DW-1:0]  b_rdata = '0;
    logic           b_ack = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_bridge #(.DATA_W(DW), .ADDR_W(AW), .BUF_AW(BAW), .MAX_BURST(MAXB), .REV(1)) i_regwin_bridge (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .b_req(b_req), .b_we(b_we),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_ack(b_ack)
    );

    // Bus slave memory model plus handshake monitor
    logic [31:0] mem [4096];
    int lat = 0;
    int wait_cnt = 0;
    int beats = 0;
    int hs_bad = 0;
    logic prev_req = 1'b0;
    logic prev_we = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_wdata = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_req && !b_ack) begin
                if (!(b_req && b_addr == prev_addr && b_we == prev_we &&
                      (!b_we || b_wdata == prev_wdata)))
                    hs_bad++;
            end
            if (prev_req && b_ack && b_req && b_addr != prev_addr + 32'd4)
                hs_bad++;
        end
        prev_req   = b_req;
        prev_we    = b_we;
        prev_addr  = b_addr;
        prev_wdata = b_wdata;
        if (b_ack) begin
            b_ack = 1'b0;
            wait_cnt = 0;
        end else if (b_req) begin
            if (wait_cnt >= lat) begin
                b_ack = 1'b1;
                beats++;
                if (b_we) mem[b_addr[13:2]] = b_wdata;
                else b_rdata = mem[b_addr[13:2]];
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [HAW-1:0] a, input logic [31:0] v);
        @(negedge clk);
        h_wr = 1'b1; h_addr = a; h_wdata = v;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic hr(input logic [HAW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        h_rd = 1'b1; h_addr = a;
        @(negedge clk);
        h_rd = 1'b0;
        v = h_rdata;
    endtask

    task automatic poll();
        logic [31:0] s;
        s = 0;
        while (s[0] !== 1'b1) hr(10'h000, s);
    endtask

    function automatic logic [HAW-1:0] rwin(input int i);
        logic [7:0] k;
        k = 8'(i);
        return {k[7:6], 2'b10, k[5:0]};
    endfunction

    function automatic logic [HAW-1:0] wwin(input int i);
        logic [7:0] k;
        k = 8'(i);
        return {k[7:6], 2'b11, k[5:0]};
    endfunction

    function automatic logic [31:0] wpat(input int run, input int i);
        return 32'hA500_0000 ^ (32'(run) << 16) ^ (32'(i) * 32'h0101);
    endfunction

    function automatic logic [31:0] rpat(input int run, input int i);
        return 32'h5A00_0000 ^ (32'(run) << 16) ^ (32'(i) * 7);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    int sizes [12] = '{0, 1, 2, 5, 63, 64, 65, 128, 255, 256, 257, 1000};

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(b_req == 1'b0, "R1 req", 32'(b_req), 0);
        hr(10'h000, v); check(v == 32'h1, "R1 status", v, 1);
        hr(10'h002, v); check(v == 32'h0, "R1 size", v, 0);

        // R2 register map, R10 read latency
        hw(10'h002, 32'h1234_5678);
        hr(10'h002, v); check(v == 32'h1234_5678, "R2 R10 size readback", v, 32'h1234_5678);
        hr(10'h003, v); check(v == 32'h0000_1001, "R2 caps", v, 32'h1001);
        hr(10'h001, v); check(v == 32'h0, "R2 ctrl", v, 0);
        hr(10'h045, v); check(v == 32'h0, "R2 unused region", v, 0);
        hw(wwin(3), 32'hCAFE_0003);
        hr(wwin(3), v); check(v == 32'h0, "R2 write window reads", v, 0);

        // Sweep of sizes and slave latencies
        foreach (sizes[run]) begin
            int n, cnt, wb, rb, errs;
            logic [31:0] first_bad_a, first_bad_e;
            n = sizes[run];
            cnt = (n == 0) ? 1 : (n > MAXB ? MAXB : n);
            lat = run % 4;
            wb = run * 300;
            rb = run * 300 + 3600 - run * 300 * 0;
            rb = (run * 40) % 3000 + 3300 - 3300 + wb; // read region reuses write base
            for (int i = 0; i < cnt; i++) hw(wwin(i), wpat(run, i));
            for (int i = 0; i <= cnt; i++) mem[wb + i] = 32'hEEEE_EEEE;
            hw(10'h002, 32'(n));
            beats = 0;
            hw(10'h008, 32'h4000_0000 + 32'(wb * 4));
            if (cnt > 1 || lat > 0) begin
                hr(10'h000, v); check(v[0] == 1'b0, "R7 busy after write start", v, 0);
            end
            poll();
            check(beats == cnt, (n > MAXB) ? "R6 write beats" : "R5 write beats", 32'(beats), 32'(cnt));
            errs = 0; first_bad_a = 0; first_bad_e = 0;
            for (int i = 0; i < cnt; i++) begin
                if (mem[wb + i] != wpat(run, i) && errs++ == 0) begin
                    first_bad_a = mem[wb + i]; first_bad_e = wpat(run, i);
                end
            end
            check(errs == 0, "R3 written data", first_bad_a, first_bad_e);
            check(mem[wb + cnt] == 32'hEEEE_EEEE, "R5 no extra write", mem[wb + cnt], 32'hEEEE_EEEE);

            rb = wb;
            for (int i = 0; i < cnt; i++) mem[rb + i] = rpat(run, i);
            beats = 0;
            hw(10'h004, 32'h6000_0000 + 32'(rb * 4));
            if (cnt > 1 || lat > 0) begin
                hr(10'h000, v); check(v[0] == 1'b0, "R7 busy after read start", v, 0);
            end
            poll();
            check(beats == cnt, (n > MAXB) ? "R6 read beats" : "R5 read beats", 32'(beats), 32'(cnt));
            errs = 0;
            for (int i = 0; i < cnt; i++) begin
                hr(rwin(i), v);
                if (v != rpat(run, i) && errs++ == 0) begin
                    first_bad_a = v; first_bad_e = rpat(run, i);
                end
            end
            check(errs == 0, "R4 read window", first_bad_a, first_bad_e);
            hr(10'h004, v);
            check(v == 32'h6000_0000 + 32'(rb * 4), "R2 start readback", v, 32'h6000_0000 + 32'(rb * 4));
        end

        // R8 writes ignored while busy
        lat = 3;
        for (int i = 0; i < 200; i++) hw(wwin(i), wpat(20, i));
        mem[3900] = 32'hBEEF_0000;
        hw(10'h002, 32'd200);
        beats = 0;
        hw(10'h008, 32'h4000_0000);
        hw(10'h002, 32'd5);
        hw(wwin(0), 32'hDEAD_DEAD);
        hw(10'h008, 32'h4000_0000 + 32'(3900 * 4));
        hw(10'h004, 32'h4000_0000 + 32'(3900 * 4));
        poll();
        repeat (8) @(negedge clk);
        check(beats == 200, "R8 no extra command", 32'(beats), 200);
        check(mem[3900] == 32'hBEEF_0000, "R8 ignored start", mem[3900], 32'hBEEF_0000);
        hr(10'h002, v); check(v == 32'd200, "R8 size kept", v, 200);
        hw(10'h002, 32'd0);
        hw(10'h008, 32'h4000_0000 + 32'(3800 * 4));
        poll();
        check(mem[3800] == wpat(20, 0), "R8 buffer kept", mem[3800], wpat(20, 0));

        check(hs_bad == 0, "R9 handshake", 32'(hs_bad), 0);
        hr(10'h000, v); check(v == 32'h1, "R7 done flag", v, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule